// File: doc/BRIEF.md
# Serial Management Bus Target

This block is the device-side end of a two-wire serial management bus. A single bidirectional data line is sampled on each rising edge of the management clock, which also clocks the block. Before each frame the target requires an unbroken run of 32 logic-one bits. After that run it accepts the frame header: a start marker, an opcode, a 5-bit device address and a 5-bit register address.

Writes and reads are handled as follows:
- **Write:** the target collects sixteen data bits. It then issues a one-cycle write strobe to an attached register bank, carrying the captured register address and data.
- **Read:** at the first turnaround bit the target latches the word that the bank presents for the received register address. It leaves the line undriven for that first turnaround bit and drives a zero for the second. It then shifts the word out most significant bit first and releases the line.

A frame is acted on only when its device address equals the strap input. The block has no storage of its own beyond the frame fields. A new frame needs a fresh run of 32 ones, so back-to-back frames without a new preamble are ignored.

Top module: `mdio_target`

## Requirements
- R1: A frame start (a zero following ones) is recognised only after at least 32 consecutive ones have been sampled while idle. A zero sampled before the run reaches 32 restarts the count, and the frame that follows is ignored.
- R2: The start marker is the bit pair 0 then 1. If the bit after the start zero is 0, the frame is abandoned with no drive and no strobe.
- R3: The opcode is two bits sent in order: 1,0 selects read and 0,1 selects write. Opcodes 0,0 and 1,1 abandon the frame, so the line stays undriven and no strobe is issued.
- R4: The device address and register address are each 5 bits, sent MSB first. The frame is acted on only when the device address equals `phy_strap`. On a mismatch, `mdio_oe` stays 0 and `reg_we` stays 0.
- R5: On a matching read, `mdio_oe` is 0 during the bit slot of the first turnaround bit. The target drives 0 (`mdio_oe`=1, `mdio_out`=0) during the second turnaround slot.
- R6: On a matching read, the 16 data bits follow in the next 16 bit slots, bit 15 first, with `mdio_oe`=1. `mdio_oe` then returns to 0, so it is high for exactly 17 consecutive slots.
- R7: The read word is taken from `reg_rdata` on the clock edge that samples the first turnaround bit, while `reg_addr` holds the received register address. Later changes to `reg_rdata` do not alter the bits shifted out.
- R8: On a matching write, the host sends turnaround 1,0 and then 16 data bits, bit 15 first. `reg_we` is then high for exactly one cycle, in the slot after the last data bit, with `reg_addr` and `reg_wdata` holding the frame's fields. `reg_we` is never high during a read.
- R9: After the last data bit the target returns to idle with the ones count cleared. A frame sent without its own new 32-one preamble is ignored.
- R10: While `rst_n` is low: `mdio_oe`=0, `mdio_out`=1 and `reg_we`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mdc | input | 1 | Management clock; inputs sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mdio_in | input | 1 | Sampled level of the data line |
| mdio_out | output | 1 | Level driven onto the data line when enabled |
| mdio_oe | output | 1 | Drive enable for the data line |
| phy_strap | input | 5 | Device address this target answers to |
| reg_addr | output | 5 | Register address of the current frame |
| reg_wdata | output | 16 | Write data presented with the strobe |
| reg_we | output | 1 | One-cycle register write strobe |
| reg_rdata | input | 16 | Register bank read data for `reg_addr` |

## Verification
The hardest situation to reach from the ports is the exact moment the read word is captured. A bank model that always answers with its stored value cannot tell a latch at the turnaround edge from one a cycle later. The bench therefore inverts the addressed bank entry in the slot right after the capture edge, and expects the old value on the line and the inverted one on the next read. Preamble boundaries are reached by sending a zero after exactly 31 ones, by breaking a long run with a zero, and by sending a frame immediately after a completed one.

// File: rtl/mdio_tgt_pkg.sv
package mdio_tgt_pkg;

  typedef enum logic [2:0] {
    PH_HUNT,
    PH_SOF,
    PH_OPC,
    PH_PHY,
    PH_REG,
    PH_TURN,
    PH_DATA
  } phase_t;

  localparam logic [1:0] OPC_RD = 2'b10;
  localparam logic [1:0] OPC_WR = 2'b01;

  // Index of the last bit of each multi-bit field.
  function automatic int unsigned field_last(phase_t ph, int unsigned aw, int unsigned dw);
    case (ph)
      PH_OPC:  return 1;
      PH_PHY:  return aw - 1;
      PH_REG:  return aw - 1;
      PH_TURN: return 1;
      PH_DATA: return dw - 1;
      default: return 0;
    endcase
  endfunction

  function automatic logic opc_known(logic [1:0] opc);
    return (opc == OPC_RD) || (opc == OPC_WR);
  endfunction

endpackage

// File: rtl/mdio_pre_det.sv
module mdio_pre_det #(
  parameter int PRE_LEN = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hunt,
  input  logic bit_in,
  output logic pre_full
);
  localparam int CW = $clog2(PRE_LEN + 1);

  logic [CW-1:0] ones_q;

  assign pre_full = (ones_q == CW'(PRE_LEN));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ones_q <= '0;
    end else if (!hunt || !bit_in) begin
      ones_q <= '0;
    end else if (!pre_full) begin
      ones_q <= ones_q + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_tgt_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_in,
  input  logic              pre_full,
  input  logic [ADDR_W-1:0] strap,
  output phase_t            phase,
  output logic              rd_frame,
  output logic              addr_hit,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              wr_pulse,
  output logic              ev_turn0,
  output logic              ev_turn1,
  output logic              ev_dat_shift,
  output logic              ev_dat_last
);
  localparam int MAXF = (DATA_W > ADDR_W) ? DATA_W : ADDR_W;
  localparam int CNT_W = $clog2(MAXF);

  phase_t            ph_q, ph_d;
  logic [CNT_W-1:0]  cnt_q;
  logic              field_end;
  logic              opc_hi_q;
  logic              rd_q, hit_q, we_q;
  logic [ADDR_W-1:0] phy_sh, reg_sh;
  logic [DATA_W-1:0] dat_sh;

  assign field_end = (32'(cnt_q) == field_last(ph_q, ADDR_W, DATA_W));

  always_comb begin
    ph_d = ph_q;
    case (ph_q)
      PH_HUNT: if (pre_full && !bit_in) ph_d = PH_SOF;
      PH_SOF:  ph_d = bit_in ? PH_OPC : PH_HUNT;
      PH_OPC:  if (field_end) ph_d = opc_known({opc_hi_q, bit_in}) ? PH_PHY : PH_HUNT;
      PH_PHY:  if (field_end) ph_d = PH_REG;
      PH_REG:  if (field_end) ph_d = PH_TURN;
      PH_TURN: if (field_end) ph_d = PH_DATA;
      PH_DATA: if (field_end) ph_d = PH_HUNT;
      default: ph_d = PH_HUNT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_HUNT;
      cnt_q <= '0;
    end else begin
      ph_q <= ph_d;
      if (ph_d != ph_q || ph_q == PH_HUNT) cnt_q <= '0;
      else cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opc_hi_q <= 1'b0;
      rd_q     <= 1'b0;
      hit_q    <= 1'b0;
      we_q     <= 1'b0;
      phy_sh   <= '0;
      reg_sh   <= '0;
      dat_sh   <= '0;
    end else begin
      we_q <= 1'b0;
      case (ph_q)
        PH_OPC: begin
          if (!field_end) opc_hi_q <= bit_in;
          else rd_q <= ({opc_hi_q, bit_in} == OPC_RD);
        end
        PH_PHY: begin
          phy_sh <= {phy_sh[ADDR_W-2:0], bit_in};
          if (field_end) hit_q <= ({phy_sh[ADDR_W-2:0], bit_in} == strap);
        end
        PH_REG: reg_sh <= {reg_sh[ADDR_W-2:0], bit_in};
        PH_DATA: begin
          dat_sh <= {dat_sh[DATA_W-2:0], bit_in};
          if (field_end) we_q <= hit_q && !rd_q;
        end
        default: ;
      endcase
    end
  end

  assign phase        = ph_q;
  assign rd_frame     = rd_q;
  assign addr_hit     = hit_q;
  assign reg_addr     = reg_sh;
  assign wr_data      = dat_sh;
  assign wr_pulse     = we_q;
  assign ev_turn0     = (ph_q == PH_TURN) && !field_end;
  assign ev_turn1     = (ph_q == PH_TURN) && field_end;
  assign ev_dat_shift = (ph_q == PH_DATA) && !field_end;
  assign ev_dat_last  = (ph_q == PH_DATA) && field_end;
endmodule

// File: rtl/mdio_rd_drv.sv
module mdio_rd_drv #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              shift,
  input  logic              stop,
  input  logic [DATA_W-1:0] rdata,
  output logic              oe,
  output logic              out
);
  logic [DATA_W-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
      oe   <= 1'b0;
      out  <= 1'b1;
    end else if (load) begin
      sh_q <= rdata;
      oe   <= 1'b1;
      out  <= 1'b0;
    end else if (shift) begin
      out  <= sh_q[DATA_W-1];
      sh_q <= {sh_q[DATA_W-2:0], 1'b0};
    end else if (stop) begin
      oe  <= 1'b0;
      out <= 1'b1;
    end
  end
endmodule

// File: rtl/mdio_target.sv
module mdio_target
  import mdio_tgt_pkg::*;
#(
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 16,
  parameter int PRE_LEN = 32
) (
  input  logic              mdc,
  input  logic              rst_n,
  input  logic              mdio_in,
  output logic              mdio_out,
  output logic              mdio_oe,
  input  logic [ADDR_W-1:0] phy_strap,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              reg_we,
  input  logic [DATA_W-1:0] reg_rdata
);
  phase_t frm_phase;
  logic   in_hunt, pre_full, rd_frame, addr_hit;
  logic   ev_turn0, ev_turn1, ev_dat_shift, ev_dat_last;
  logic   serve, drv_load, drv_shift;

  assign in_hunt   = (frm_phase == PH_HUNT);
  assign serve     = rd_frame && addr_hit;
  assign drv_load  = ev_turn0 && serve;
  assign drv_shift = (ev_turn1 || ev_dat_shift) && serve;

  mdio_pre_det #(.PRE_LEN(PRE_LEN)) u_pre (
    .clk      (mdc),
    .rst_n    (rst_n),
    .hunt     (in_hunt),
    .bit_in   (mdio_in),
    .pre_full (pre_full)
  );

  mdio_frame_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk          (mdc),
    .rst_n        (rst_n),
    .bit_in       (mdio_in),
    .pre_full     (pre_full),
    .strap        (phy_strap),
    .phase        (frm_phase),
    .rd_frame     (rd_frame),
    .addr_hit     (addr_hit),
    .reg_addr     (reg_addr),
    .wr_data      (reg_wdata),
    .wr_pulse     (reg_we),
    .ev_turn0     (ev_turn0),
    .ev_turn1     (ev_turn1),
    .ev_dat_shift (ev_dat_shift),
    .ev_dat_last  (ev_dat_last)
  );

  mdio_rd_drv #(.DATA_W(DATA_W)) u_drv (
    .clk   (mdc),
    .rst_n (rst_n),
    .load  (drv_load),
    .shift (drv_shift),
    .stop  (ev_dat_last),
    .rdata (reg_rdata),
    .oe    (mdio_oe),
    .out   (mdio_out)
  );
endmodule

// File: rtl/mdio_target_chk.sv
module mdio_target_chk
  import mdio_tgt_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int PRE_LEN = 32
) (
  input logic   mdc,
  input logic   rst_n,
  input logic   mdio_in,
  input logic   mdio_oe,
  input logic   mdio_out,
  input logic   reg_we,
  input logic   addr_hit,
  input phase_t frm_phase
);
  localparam int OW = $clog2(PRE_LEN + 1);
  localparam int RW = $clog2(DATA_W + 3);

  logic [OW-1:0] ones_run;
  logic [RW-1:0] oe_run;

  always_ff @(posedge mdc or negedge rst_n) begin
    if (!rst_n) begin
      ones_run <= '0;
      oe_run   <= '0;
    end else begin
      if (!mdio_in) ones_run <= '0;
      else if (ones_run != OW'(PRE_LEN)) ones_run <= ones_run + 1'b1;
      if (!mdio_oe) oe_run <= '0;
      else if (oe_run != '1) oe_run <= oe_run + 1'b1;
    end
  end

  assert_pre_seen_R1: assert property (@(posedge mdc) disable iff (!rst_n)
    (frm_phase == PH_SOF) |-> ($past(ones_run) == OW'(PRE_LEN)));

  assert_sof_one_R2: assert property (@(posedge mdc) disable iff (!rst_n)
    (frm_phase == PH_OPC && $past(frm_phase) == PH_SOF) |-> $past(mdio_in));

  assert_opc_pair_R3: assert property (@(posedge mdc) disable iff (!rst_n)
    (frm_phase == PH_PHY && $past(frm_phase) == PH_OPC) |-> ($past(mdio_in) != $past(mdio_in, 2)));

  assert_drive_needs_hit_R4: assert property (@(posedge mdc) disable iff (!rst_n)
    mdio_oe |-> addr_hit);

  assert_turn_zero_R5: assert property (@(posedge mdc) disable iff (!rst_n)
    $rose(mdio_oe) |-> !mdio_out);

  assert_drive_len_R6: assert property (@(posedge mdc) disable iff (!rst_n)
    $fell(mdio_oe) |-> (oe_run == RW'(DATA_W + 1)));

  assert_we_pulse_R8: assert property (@(posedge mdc) disable iff (!rst_n)
    reg_we |=> !reg_we);

  assert_we_idle_R8: assert property (@(posedge mdc) disable iff (!rst_n)
    reg_we |-> (!mdio_oe && frm_phase == PH_HUNT));

  assert_sof_quiet_R9: assert property (@(posedge mdc) disable iff (!rst_n)
    (frm_phase == PH_SOF) |-> !mdio_oe);
endmodule

bind mdio_target mdio_target_chk #(.DATA_W(DATA_W), .PRE_LEN(PRE_LEN)) u_chk (
  .mdc       (mdc),
  .rst_n     (rst_n),
  .mdio_in   (mdio_in),
  .mdio_oe   (mdio_oe),
  .mdio_out  (mdio_out),
  .reg_we    (reg_we),
  .addr_hit  (addr_hit),
  .frm_phase (frm_phase)
);

// File: tb/mdio_target_tb.sv
`timescale 1ns/1ps
module mdio_target_tb;
  localparam int AW = 5;
  localparam int DW = 16;

  typedef struct {
    bit        din;
    bit        e_oe;
    bit        e_out;
    bit        e_we;
    bit [4:0]  e_addr;
    bit [15:0] e_data;
    bit        poke;
    string     tag;
  } slot_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          host_bit = 1'b1;
  logic [AW-1:0] strap = 5'h0B;
  logic          mdio_out, mdio_oe, reg_we;
  logic [AW-1:0] reg_addr;
  logic [DW-1:0] reg_wdata, reg_rdata;
  logic          line;
  logic [DW-1:0] bank [32];
  slot_t         q[$];
  int            n_chk = 0;
  int            n_fail = 0;
  bit            done = 0;

  always #2 clk = ~clk;

  assign line      = mdio_oe ? mdio_out : host_bit;
  assign reg_rdata = bank[reg_addr];

  mdio_target u_dut (
    .mdc       (clk),
    .rst_n     (rst_n),
    .mdio_in   (line),
    .mdio_out  (mdio_out),
    .mdio_oe   (mdio_oe),
    .phy_strap (strap),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_we    (reg_we),
    .reg_rdata (reg_rdata)
  );

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic check(bit ok, string tag, string what, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic void add(bit d, string tag, bit oe, bit out, bit we,
                              bit [4:0] a, bit [15:0] dat, bit poke);
    slot_t s;
    s.din = d; s.tag = tag; s.e_oe = oe; s.e_out = out; s.e_we = we;
    s.e_addr = a; s.e_data = dat; s.poke = poke;
    q.push_back(s);
  endfunction

  function automatic void ones(int n, string tag);
    for (int i = 0; i < n; i++) add(1'b1, tag, 0, 0, 0, 0, 0, 0);
  endfunction

  // Expected behaviour of one frame, derived from the requirements.
  function automatic void build_frame(bit [1:0] st, bit [1:0] op, bit [4:0] pa, bit [4:0] ra,
                                      bit [15:0] wd, bit pre_ok, string tag);
    bit act, rd;
    bit [15:0] word;
    act  = pre_ok && (st == 2'b01) && (op == 2'b10 || op == 2'b01) && (pa == strap);
    rd   = (op == 2'b10);
    word = bank[ra];
    for (int i = 1; i >= 0; i--) add(st[i], tag, 0, 0, 0, 0, 0, 0);
    for (int i = 1; i >= 0; i--) add(op[i], tag, 0, 0, 0, 0, 0, 0);
    for (int i = 4; i >= 0; i--) add(pa[i], tag, 0, 0, 0, 0, 0, 0);
    for (int i = 4; i >= 0; i--) add(ra[i], tag, 0, 0, 0, 0, 0, 0);
    if (rd) begin
      add(1'b1, "R5", 0, 0, 0, 0, 0, 0);
      add(1'b1, "R5", act, 1'b0, 0, ra, 0, act);
      for (int i = 15; i >= 0; i--) add(1'b1, tag, act, word[i], 0, 0, 0, 0);
    end else begin
      add(1'b1, tag, 0, 0, 0, 0, 0, 0);
      add(1'b0, tag, 0, 0, 0, 0, 0, 0);
      for (int i = 15; i >= 0; i--) add(wd[i], tag, 0, 0, 0, 0, 0, 0);
    end
    add(1'b1, tag, 0, 0, act && !rd, ra, wd, 0);
  endfunction

  task automatic play();
    slot_t s;
    while (q.size() != 0) begin
      s = q.pop_front();
      @(negedge clk);
      check(mdio_oe === s.e_oe, s.tag, "mdio_oe", 16'(mdio_oe), 16'(s.e_oe));
      if (s.e_oe) check(mdio_out === s.e_out, s.tag, "mdio_out", 16'(mdio_out), 16'(s.e_out));
      check(reg_we === s.e_we, s.tag, "reg_we", 16'(reg_we), 16'(s.e_we));
      if (s.e_we) begin
        check(reg_addr === s.e_addr, s.tag, "reg_addr", 16'(reg_addr), 16'(s.e_addr));
        check(reg_wdata === s.e_data, s.tag, "reg_wdata", reg_wdata, s.e_data);
      end
      if (reg_we === 1'b1) bank[reg_addr] = reg_wdata;
      if (s.poke) bank[s.e_addr] = ~bank[s.e_addr];
      host_bit = s.din;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R6: got timeout expected completion");
    finish_up();
  end

  initial begin
    for (int i = 0; i < 32; i++) bank[i] = 16'((i * 4369) ^ 23055);
    repeat (3) @(negedge clk);
    // R10: quiet outputs while in reset
    check(mdio_oe === 1'b0, "R10", "mdio_oe", 16'(mdio_oe), 16'h0);
    check(mdio_out === 1'b1, "R10", "mdio_out", 16'(mdio_out), 16'h1);
    check(reg_we === 1'b0, "R10", "reg_we", 16'(reg_we), 16'h0);
    rst_n = 1'b1;

    // R8: matching write
    ones(32, "R1"); build_frame(2'b01, 2'b01, strap, 5'd3, 16'hA5C3, 1, "R8"); play();
    // R7: read back, word inverted right after the capture edge
    ones(32, "R1"); build_frame(2'b01, 2'b10, strap, 5'd3, 0, 1, "R7"); play();
    ones(32, "R1"); build_frame(2'b01, 2'b10, strap, 5'd3, 0, 1, "R7"); play();
    // R6: longer preamble, default register
    ones(40, "R1"); build_frame(2'b01, 2'b10, strap, 5'd9, 0, 1, "R6"); play();
    // R4: mismatched device address, then confirm register unchanged
    ones(32, "R4"); build_frame(2'b01, 2'b01, strap ^ 5'h01, 5'd9, 16'h1234, 1, "R4"); play();
    ones(32, "R4"); build_frame(2'b01, 2'b10, strap ^ 5'h10, 5'd9, 0, 1, "R4"); play();
    ones(32, "R4"); build_frame(2'b01, 2'b10, strap, 5'd9, 0, 1, "R4"); play();
    // R1: only 31 ones before the start zero
    add(1'b0, "R1", 0, 0, 0, 0, 0, 0); ones(31, "R1");
    build_frame(2'b01, 2'b01, strap, 5'd9, 16'hFFFF, 0, "R1"); play();
    // R1: long run broken by a zero
    ones(20, "R1"); add(1'b0, "R1", 0, 0, 0, 0, 0, 0); ones(31, "R1");
    build_frame(2'b01, 2'b01, strap, 5'd9, 16'hFFFF, 0, "R1"); play();
    ones(32, "R1"); build_frame(2'b01, 2'b10, strap, 5'd9, 0, 1, "R1"); play();
    // R3: unknown opcodes
    ones(32, "R3"); build_frame(2'b01, 2'b11, strap, 5'd9, 16'h0000, 1, "R3"); play();
    ones(32, "R3"); build_frame(2'b01, 2'b00, strap, 5'd9, 16'h0000, 1, "R3"); play();
    ones(32, "R3"); build_frame(2'b01, 2'b10, strap, 5'd9, 0, 1, "R3"); play();
    // R2: start marker 0,0
    ones(32, "R2"); build_frame(2'b00, 2'b01, strap, 5'd9, 16'h0000, 1, "R2"); play();
    ones(32, "R2"); build_frame(2'b01, 2'b10, strap, 5'd9, 0, 1, "R2"); play();
    // R9: second frame without a fresh preamble
    ones(32, "R9"); build_frame(2'b01, 2'b01, strap, 5'd12, 16'h0F0F, 1, "R8");
    build_frame(2'b01, 2'b01, strap, 5'd12, 16'hF0F0, 0, "R9"); play();
    ones(32, "R9"); build_frame(2'b01, 2'b10, strap, 5'd12, 0, 1, "R9"); play();
    // R4: other strap value, highest register address
    strap = 5'h1F;
    ones(32, "R4"); build_frame(2'b01, 2'b01, strap, 5'd31, 16'h8001, 1, "R4"); play();
    ones(32, "R4"); build_frame(2'b01, 2'b10, strap, 5'd31, 0, 1, "R4"); play();
    ones(4, "R9"); play();
    finish_up();
  end
endmodule